// File: doc/BRIEF.md
# Triggered Fixed-Length Burst Shifter

This block is a parameterised shift register that sits idle until it sees its start request. When `start` is high while the block is idle, the block captures the parallel word and then performs exactly `WIDTH` single-bit shifts. It does one shift on each rising clock edge, one after the other. During a burst the register moves toward its most significant bit. The serial input enters at bit 0, and the bit held in the top position is what appears on the serial output.

Once a burst has started, the start input is ignored until the burst has finished. A single-cycle pulse and a long level therefore both give the same full burst. If the request is still high when the burst ends, the next burst begins after one idle cycle in which the next word is loaded.

Top module: `burst_shifter`

## Requirements
- R1: An active-high asynchronous `rst` clears the register to all zeros and forces idle, so `ser_out`=0 and `busy`=0.
- R2: On an edge where the block is idle and `start`=1, `par_in` is loaded and `busy` is 1 from that edge on. Directly after the load, `ser_out` equals `par_in[WIDTH-1]`.
- R3: `busy` stays high for exactly `WIDTH` consecutive cycles per burst and then drops to 0.
- R4: Any value on `start` while `busy`=1 has no effect on the length or the data of the running burst.
- R5: Each shift moves every bit one place toward the MSB and takes `ser_in` into bit 0. `ser_out` is always the registered MSB.
- R6: Exactly one shift happens per clock edge. After the k-th shift (k < WIDTH), `ser_out` equals `par_in[WIDTH-1-k]` of the loaded word.
- R7: While idle with `start`=0, `ser_out` holds its value and changes on `par_in` or `ser_in` have no effect.
- R8: A `start` held high produces back-to-back bursts, separated by exactly one cycle in which `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Burst request, sampled only while idle |
| par_in | input | WIDTH | Word loaded when a burst starts |
| ser_in | input | 1 | Bit shifted into bit 0 on each shift |
| ser_out | output | 1 | Registered MSB of the shift register |
| busy | output | 1 | High while a burst is in progress |

## Verification
The block is first driven with a one-cycle start pulse. This separates a self-timed burst from a design that only shifts while the request is high. Start is then toggled during a running burst, which shows whether a late request can stretch, restart or reload the burst. A long held request shows whether the one-cycle load gap appears between bursts. Idle stretches with changing data show that neither the parallel word nor the serial input can reach the output without a request.

// File: rtl/burst_shift_pkg.sv
package burst_shift_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_t;

   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
   import burst_shift_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic shift,
   output logic busy
);
   localparam int CNT_W = cnt_bits(WIDTH);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   phase_t           phase_q;
   logic [CNT_W-1:0] done_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         done_q  <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q <= PH_RUN;
                  done_q  <= '0;
               end
            end
            PH_RUN: begin
               if (done_q == LAST) begin
                  phase_q <= PH_IDLE;
                  done_q  <= '0;
               end else begin
                  done_q  <= done_q + 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      load  = (phase_q == PH_IDLE) && start;
      shift = (phase_q == PH_RUN);
      busy  = (phase_q == PH_RUN);
   end

endmodule

// File: rtl/shift_core.sv
module shift_core #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic             ser_out
);
   logic [WIDTH-1:0] bits_q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic feed;
      if (i == 0) begin : g_head
         assign feed = ser_in;
      end else begin : g_chain
         assign feed = bits_q[i-1];
      end

      always_ff @(posedge clk or posedge rst) begin
         if (rst)        bits_q[i] <= 1'b0;
         else if (load)  bits_q[i] <= par_in[i];
         else if (shift) bits_q[i] <= feed;
      end
   end

   assign ser_out = bits_q[WIDTH-1];

endmodule

// File: rtl/burst_shifter.sv
module burst_shifter #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic             ser_out,
   output logic             busy
);
   if (WIDTH < 2) begin : g_bad_width
      $error("burst_shifter: WIDTH must be at least 2");
   end

   logic load;
   logic shift;

   burst_seq #(.WIDTH(WIDTH)) u_seq (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .load  (load),
      .shift (shift),
      .busy  (busy)
   );

   shift_core #(.WIDTH(WIDTH)) u_core (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .shift   (shift),
      .par_in  (par_in),
      .ser_in  (ser_in),
      .ser_out (ser_out)
   );

endmodule

// File: rtl/burst_shifter_chk.sv
module burst_shifter_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic [WIDTH-1:0] par_in,
   input logic             ser_in,
   input logic             ser_out,
   input logic             busy
);
   int run_len;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       run_len <= 0;
      else if (busy) run_len <= run_len + 1;
      else           run_len <= 0;
   end

   // R1
   always @(posedge clk) begin
      if (rst) begin
         reset_clear_chk: assert (!busy && !ser_out);
      end
   end

   // R2
   launch_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && start) |=> (busy && ser_out == $past(par_in[WIDTH-1])));

   // R3
   burst_end_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && run_len == WIDTH - 1) |=> !busy);

   // R4
   burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && run_len < WIDTH - 1) |=> busy);

   // R3
   run_bound_chk: assert property (@(posedge clk) disable iff (rst)
      busy |-> (run_len < WIDTH));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> (!busy && $stable(ser_out)));

   // R8
   gap_one_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && start) |=> busy);

endmodule

bind burst_shifter burst_shifter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .par_in  (par_in),
   .ser_in  (ser_in),
   .ser_out (ser_out),
   .busy    (busy)
);

// File: tb/test_burst_shifter.sv
`timescale 1ns/1ps
module test_burst_shifter;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [W-1:0] par_in = '0;
   logic         ser_in = 1'b0;
   logic         ser_out;
   logic         busy;

   int n_checks = 0;
   int n_errors = 0;
   int cycles = 0;

   bit model_q[$];
   int remaining = 0;

   always #2.5 clk = ~clk;

   burst_shifter #(.WIDTH(W)) i_burst_shifter (
      .clk(clk), .rst(rst), .start(start), .par_in(par_in),
      .ser_in(ser_in), .ser_out(ser_out), .busy(busy)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cycles, act, exp);
      end
   endtask

   // behavioural reference: a queue of bits, front is the MSB
   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         model_q.delete();
         for (int i = 0; i < W; i++) model_q.push_back(1'b0);
         remaining = 0;
      end else if (remaining == 0) begin
         if (start) begin
            model_q.delete();
            for (int i = W - 1; i >= 0; i--) model_q.push_back(par_in[i]);
            remaining = W;
         end
      end else begin
         void'(model_q.pop_front());
         model_q.push_back(ser_in);
         remaining--;
      end
      if (cycles > 5000) begin
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!rst && model_q.size() == W) begin
         check("R3 busy vs model", busy, remaining > 0);
         check("R5 ser_out vs model", ser_out, model_q[0]);
      end
   end

   initial begin
      int gap;
      logic seen [W];
      repeat (3) @(negedge clk);
      check("R1 reset busy", busy, 1'b0);
      check("R1 reset ser_out", ser_out, 1'b0);
      rst = 1'b0;

      // R7: idle with moving data
      for (int i = 0; i < 5; i++) begin
         par_in = W'(i * 5 + 3); ser_in = i[0];
         @(negedge clk);
         check("R7 idle ser_out held", ser_out, 1'b0);
         check("R7 idle busy", busy, 1'b0);
      end

      // R2/R6: single pulse, word 1011, serial bits 1,1,0,0
      par_in = 4'b1011; start = 1'b1;
      @(negedge clk);
      start = 1'b0; par_in = 4'b0000;
      check("R2 busy after load", busy, 1'b1);
      check("R2 ser_out is loaded MSB", ser_out, 1'b1);
      for (int k = 1; k <= W; k++) begin
         ser_in = (k <= 2);
         @(negedge clk);
         seen[k-1] = ser_out;
      end
      check("R6 shift1", seen[0], 1'b0);
      check("R6 shift2", seen[1], 1'b1);
      check("R6 shift3", seen[2], 1'b1);
      check("R5 shift4 first serial bit", seen[3], 1'b1);
      check("R3 busy low after burst", busy, 1'b0);

      // R4: toggle start during a burst
      par_in = 4'b0110; start = 1'b1;
      @(negedge clk);
      for (int k = 0; k < W - 1; k++) begin
         start = k[0]; par_in = 4'b1001; ser_in = 1'b0;
         @(negedge clk);
         check("R4 burst unaffected by start", busy, 1'b1);
      end
      start = 1'b0;
      @(negedge clk);
      check("R4 burst ends on time", busy, 1'b0);
      repeat (2) @(negedge clk);

      // R8: held start
      par_in = 4'b1100; start = 1'b1;
      @(negedge clk);
      repeat (W) @(negedge clk);
      gap = 0;
      while (!busy && gap < 10) begin
         gap++;
         @(negedge clk);
      end
      check("R8 single idle cycle between bursts", gap == 1, 1'b1);
      repeat (2 * W + 3) @(negedge clk);
      start = 1'b0;
      repeat (W + 3) @(negedge clk);
      check("R8 idle after release", busy, 1'b0);

      // R1: reset in the middle of a burst
      start = 1'b1; par_in = 4'b1111;
      @(negedge clk);
      start = 1'b0;
      #1 rst = 1'b1;
      #0.5;
      check("R1 async reset busy", busy, 1'b0);
      check("R1 async reset ser_out", ser_out, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule